// File: doc/BRIEF.md
# Integer Execution Unit with Carry and Flag Status

This block is the integer execute stage of a 32-bit processor pipeline. Each cycle it may accept one operation, given as an operation code and two operands. Most operations finish in a single cycle and present a registered result. Signed and unsigned divide run on an iterative divider and occupy the unit for one cycle per result bit. While the divider is running the unit reports busy.

The unit owns two status bits, carry and flag, and drives them out directly. Addition sets carry by comparing the wrapped sum against the first operand. When the arithmetic-flag mode input is high, add, add-with-carry and AND also set the flag from a zero test of their result. Conditional move reads the flag to pick its operand. A divide by zero produces no result and leaves the status bits alone. Instead, the unit raises a one-cycle illegal-instruction pulse that the exception logic picks up.

Top module: `ixu_core`

## Requirements
- R1: An operation is accepted on a rising clock edge where `valid_i` is high and `busy_o` is low. Operation codes are: 0 add, 1 add-with-carry, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 shift left, 7 logical shift right, 8 arithmetic shift right, 9 move-high, 10 sign-extend byte, 11 zero-extend byte, 12 sign-extend halfword, 13 zero-extend halfword, 14 conditional move, 15 find-first-one, 16 signed divide, 17 unsigned divide. Codes 0 to 15 put their result on `res_o` with `res_valid_o` high for exactly the one cycle after the accepting edge.
- R2: Add gives `a_i + b_i` and add-with-carry gives `a_i + b_i + carry_o`, both modulo 2^32. Subtract gives `a_i - b_i`. AND, OR and XOR give the bitwise result of the two operands.
- R3: After add or add-with-carry, `carry_o` is 1 when the 32-bit unsigned result is below `a_i` and 0 otherwise. This rule holds even when it differs from the true carry-out, for example add-with-carry of `b_i` = 0xFFFFFFFF with carry set.
- R4: With `arith_flag_en_i` high, add, add-with-carry and AND set `flag_o` to 1 on a zero result and to 0 on a nonzero result. With `arith_flag_en_i` low, no operation changes `flag_o`.
- R5: Every operation other than add and add-with-carry leaves `carry_o` unchanged. Every operation other than add, add-with-carry and AND leaves `flag_o` unchanged.
- R6: The shifts use only `b_i[4:0]` as the amount. Shift left and logical shift right fill with zeros. Arithmetic shift right fills with copies of `a_i[31]`.
- R7: Move-high returns `{b_i[15:0], 16'h0000}`.
- R8: The extend operations take `a_i[7:0]` or `a_i[15:0]` and widen it to 32 bits by copying its top bit or by filling with zeros.
- R9: Conditional move returns `a_i` when `flag_o` is 1 and `b_i` when it is 0.
- R10: Find-first-one returns the 1-based index of the lowest set bit of `a_i`, or 0 when `a_i` is zero.
- R11: A divide with a nonzero `b_i` raises `busy_o` from the accepting edge. Exactly 32 edges later, `busy_o` falls and `res_valid_o` is high for one cycle with the quotient. Signed divide truncates toward zero, and 0x80000000 / 0xFFFFFFFF gives 0x80000000.
- R12: A divide with `b_i` = 0 raises `illegal_o` for the one cycle after the accepting edge. It produces no `res_valid_o`, does not raise `busy_o`, and leaves `carry_o` and `flag_o` unchanged.
- R13: While `busy_o` is high, `valid_i` is ignored. No result appears except the divide quotient, and the status bits do not change.
- R14: While `rst_ni` is low, `res_valid_o`, `busy_o`, `illegal_o`, `carry_o` and `flag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; also the immediate for move-high |
| arith_flag_en_i | input | 1 | Arithmetic-flag mode: lets add, add-with-carry and AND update the flag |
| res_o | output | 32 | Result |
| res_valid_o | output | 1 | Result valid, one cycle per result |
| busy_o | output | 1 | Divider running; requests are ignored |
| illegal_o | output | 1 | Divide-by-zero exception pulse |
| carry_o | output | 1 | Carry status bit |
| flag_o | output | 1 | Condition flag status bit |

## Verification
Single-cycle operations have their result, carry and flag due after the first rising edge following acceptance. The bench drives inputs on falling edges and reads outputs on the very next falling edge. A divide with a nonzero divisor is due 32 edges after the accepting edge. The bench counts those falling edges and expects `res_valid_o` low on every one except the last. A zero divisor is due one edge after acceptance, as an `illegal_o` pulse with no result. The bench also drives a request in the middle of a divide and then checks that the status bits still match its own model once the quotient arrives.

// File: rtl/ixu_pkg.sv
package ixu_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUB   = 5'd2,
    OP_AND   = 5'd3,
    OP_OR    = 5'd4,
    OP_XOR   = 5'd5,
    OP_SLL   = 5'd6,
    OP_SRL   = 5'd7,
    OP_SRA   = 5'd8,
    OP_MOVHI = 5'd9,
    OP_EXTBS = 5'd10,
    OP_EXTBZ = 5'd11,
    OP_EXTHS = 5'd12,
    OP_EXTHZ = 5'd13,
    OP_CMOV  = 5'd14,
    OP_FF1   = 5'd15,
    OP_DIV   = 5'd16,
    OP_DIVU  = 5'd17
  } ixu_op_e;
endpackage

// File: rtl/ixu_ffo.sv
module ixu_ffo #(
  parameter int unsigned W = 32,
  localparam int unsigned PW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d_i,
  output logic [PW-1:0] pos_o
);
  // scan from the top so the lowest set bit wins
  always_comb begin
    pos_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (d_i[i]) pos_o = PW'(i + 1);
    end
  end
endmodule

// File: rtl/ixu_arith.sv
module ixu_arith
  import ixu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            carry_i,
  input  logic            flag_i,
  output logic [W-1:0]    res_o,
  output logic            carry_nxt_o,
  output logic            wr_carry_o,
  output logic            flag_cand_o,
  output logic            single_o
);
  localparam int unsigned SH   = $clog2(W);
  localparam int unsigned HALF = W / 2;
  localparam int unsigned PW   = $clog2(W + 1);

  logic [W-1:0]  sum;
  logic [SH-1:0] shamt;
  logic [PW-1:0] ff_pos;

  ixu_ffo #(.W(W)) u_ffo (.d_i(a_i), .pos_o(ff_pos));

  assign shamt = b_i[SH-1:0];
  assign sum   = a_i + b_i + {{(W-1){1'b0}}, (op_i == OP_ADDC) & carry_i};

  // carry rule is a wrap compare, not the adder carry-out
  assign carry_nxt_o = sum < a_i;
  assign wr_carry_o  = (op_i == OP_ADD) | (op_i == OP_ADDC);
  assign flag_cand_o = wr_carry_o | (op_i == OP_AND);
  assign single_o    = op_i <= OP_W'(OP_FF1);

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_ADDC: res_o = sum;
      OP_SUB:   res_o = a_i - b_i;
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_SLL:   res_o = a_i << shamt;
      OP_SRL:   res_o = a_i >> shamt;
      OP_SRA:   res_o = W'($signed(a_i) >>> shamt);
      OP_MOVHI: res_o = {b_i[HALF-1:0], {HALF{1'b0}}};
      OP_EXTBS: res_o = {{(W-8){a_i[7]}}, a_i[7:0]};
      OP_EXTBZ: res_o = {{(W-8){1'b0}}, a_i[7:0]};
      OP_EXTHS: res_o = {{(W-16){a_i[15]}}, a_i[15:0]};
      OP_EXTHZ: res_o = {{(W-16){1'b0}}, a_i[15:0]};
      OP_CMOV:  res_o = flag_i ? a_i : b_i;
      OP_FF1:   res_o = W'(ff_pos);
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/ixu_div.sv
module ixu_div #(
  parameter int unsigned W = 32,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  logic [CW-1:0] cnt_q;
  logic [W:0]    rem_q, rem_sh, trial, rem_n;
  logic [W-1:0]  quo_q, quo_n, dvs_q, a_abs, b_abs;
  logic          neg_q, fits;

  assign a_abs = (signed_i & dividend_i[W-1]) ? -dividend_i : dividend_i;
  assign b_abs = (signed_i & divisor_i[W-1])  ? -divisor_i  : divisor_i;

  // one restoring step per cycle
  assign rem_sh = {rem_q[W-1:0], quo_q[W-1]};
  assign trial  = rem_sh - {1'b0, dvs_q};
  assign fits   = ~trial[W];
  assign rem_n  = fits ? trial : rem_sh;
  assign quo_n  = {quo_q[W-2:0], fits};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      neg_q  <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else if (start_i && !busy_o) begin
      cnt_q  <= CW'(W);
      rem_q  <= '0;
      quo_q  <= a_abs;
      dvs_q  <= b_abs;
      neg_q  <= signed_i & (dividend_i[W-1] ^ divisor_i[W-1]);
      busy_o <= 1'b1;
      done_o <= 1'b0;
    end else if (busy_o) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        quo_o  <= neg_q ? -quo_n : quo_n;
      end
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ixu_core.sv
module ixu_core
  import ixu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            arith_flag_en_i,
  output logic [W-1:0]    res_o,
  output logic            res_valid_o,
  output logic            busy_o,
  output logic            illegal_o,
  output logic            carry_o,
  output logic            flag_o
);
  logic [W-1:0] alu_res, res_q, div_q;
  logic         carry_nxt, wr_carry, flag_cand, single_op;
  logic         accept, is_div, div_zero, div_start, div_busy, div_done;
  logic         res_vld_q, carry_q, flag_q, illegal_q;

  ixu_arith #(.W(W)) u_arith (
    .op_i        (op_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .carry_i     (carry_q),
    .flag_i      (flag_q),
    .res_o       (alu_res),
    .carry_nxt_o (carry_nxt),
    .wr_carry_o  (wr_carry),
    .flag_cand_o (flag_cand),
    .single_o    (single_op)
  );

  assign accept    = valid_i & ~div_busy;
  assign is_div    = accept & ((op_i == OP_DIV) | (op_i == OP_DIVU));
  assign div_zero  = is_div & (b_i == '0);
  assign div_start = is_div & ~div_zero;

  ixu_div #(.W(W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .signed_i   (op_i == OP_DIV),
    .dividend_i (a_i),
    .divisor_i  (b_i),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quo_o      (div_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q     <= '0;
      res_vld_q <= 1'b0;
      carry_q   <= 1'b0;
      flag_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      res_vld_q <= accept & single_op;
      illegal_q <= div_zero;
      if (accept && single_op) begin
        res_q <= alu_res;
        if (wr_carry) carry_q <= carry_nxt;
        if (flag_cand && arith_flag_en_i) flag_q <= (alu_res == '0);
      end
    end
  end

  // divider completion and single-cycle results never coincide
  assign res_o       = div_done ? div_q : res_q;
  assign res_valid_o = res_vld_q | div_done;
  assign busy_o      = div_busy;
  assign illegal_o   = illegal_q;
  assign carry_o     = carry_q;
  assign flag_o      = flag_q;
endmodule

// File: rtl/ixu_chk.sv
module ixu_chk
  import ixu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic            arith_flag_en_i,
  input logic [W-1:0]    res_o,
  input logic            res_valid_o,
  input logic            busy_o,
  input logic            illegal_o,
  input logic            carry_o,
  input logic            flag_o
);
  logic take, div_op;
  assign take   = valid_i & ~busy_o;
  assign div_op = (op_i == OP_DIV) | (op_i == OP_DIVU);

  AST_SINGLE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i <= OP_W'(OP_FF1)) |=> res_valid_o); // R1
  AST_ADD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i == OP_ADD) |=> carry_o == (res_o < $past(a_i))); // R3
  AST_FLAG_MODE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !arith_flag_en_i |=> $stable(flag_o)); // R4
  AST_STATUS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i == OP_SUB || op_i == OP_OR || op_i == OP_XOR)
    |=> $stable(carry_o) && $stable(flag_o)); // R5
  AST_DIV_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && div_op && (b_i != '0) |=> busy_o && !res_valid_o); // R11
  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && div_op && (b_i == '0)
    |=> illegal_o && !busy_o && $stable(carry_o) && $stable(flag_o)); // R12
  AST_NO_WB_ON_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !res_valid_o); // R12
  AST_BUSY_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !res_valid_o && !illegal_o); // R13
  AST_BUSY_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(carry_o) && $stable(flag_o)); // R13
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!res_valid_o && !busy_o && !illegal_o && !carry_o && !flag_o); // R14
    end
  end
endmodule

bind ixu_core ixu_chk #(.W(W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .valid_i         (valid_i),
  .op_i            (op_i),
  .a_i             (a_i),
  .b_i             (b_i),
  .arith_flag_en_i (arith_flag_en_i),
  .res_o           (res_o),
  .res_valid_o     (res_valid_o),
  .busy_o          (busy_o),
  .illegal_o       (illegal_o),
  .carry_o         (carry_o),
  .flag_o          (flag_o)
);

// File: tb/ixu_core_bench.sv
`timescale 1ns/1ps
module ixu_core_bench;
  import ixu_pkg::*;
  localparam int W      = 32;
  localparam int CLK_NS = 4;

  logic         clk = 1'b0, rst_ni = 1'b0, valid = 1'b0, en = 1'b0;
  logic [4:0]   op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] res_o;
  logic         res_valid_o, busy_o, illegal_o, carry_o, flag_o;
  int           total = 0, fails = 0;
  logic         mc = 1'b0, mf = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  ixu_core #(.W(W)) u_ixu_core (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid), .op_i (op),
    .a_i (a), .b_i (b), .arith_flag_en_i (en),
    .res_o (res_o), .res_valid_o (res_valid_o), .busy_o (busy_o),
    .illegal_o (illegal_o), .carry_o (carry_o), .flag_o (flag_o)
  );

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ff1_ref(logic [W-1:0] x);
    for (int i = 0; i < W; i++) if (x[i]) return W'(i + 1);
    return '0;
  endfunction

  function automatic logic [W-1:0] ref_res(logic [4:0] o, logic [W-1:0] x, logic [W-1:0] y,
                                           logic c, logic f);
    case (o)
      OP_ADD:   return x + y;
      OP_ADDC:  return x + y + W'(c);
      OP_SUB:   return x - y;
      OP_AND:   return x & y;
      OP_OR:    return x | y;
      OP_XOR:   return x ^ y;
      OP_SLL:   return x << y[4:0];
      OP_SRL:   return x >> y[4:0];
      OP_SRA:   return W'($signed(x) >>> y[4:0]);
      OP_MOVHI: return {y[15:0], 16'h0000};
      OP_EXTBS: return {{24{x[7]}}, x[7:0]};
      OP_EXTBZ: return {24'h0, x[7:0]};
      OP_EXTHS: return {{16{x[15]}}, x[15:0]};
      OP_EXTHZ: return {16'h0, x[15:0]};
      OP_CMOV:  return f ? x : y;
      OP_FF1:   return ff1_ref(x);
      default:  return '0;
    endcase
  endfunction

  function automatic string req_of(logic [4:0] o);
    if (o <= 5'd5) return "R2";
    if (o <= 5'd8) return "R6";
    if (o == 5'd9) return "R7";
    if (o <= 5'd13) return "R8";
    if (o == 5'd14) return "R9";
    return "R10";
  endfunction

  task automatic run_single(logic [4:0] o, logic [W-1:0] x, logic [W-1:0] y, logic e);
    logic [W-1:0] er;
    logic ec, ef, is_add, flag_upd;
    is_add   = (o == OP_ADD) || (o == OP_ADDC);
    flag_upd = e && (is_add || o == OP_AND);
    er = ref_res(o, x, y, mc, mf);
    ec = is_add ? (er < x) : mc;
    ef = flag_upd ? (er == '0) : mf;
    @(negedge clk);
    op = o; a = x; b = y; en = e; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R1", "res_valid", W'(res_valid_o), W'(1));
    check(req_of(o), "result", res_o, er);
    check(is_add ? "R3" : "R5", "carry", W'(carry_o), W'(ec));
    check(flag_upd ? "R4" : "R5", "flag", W'(flag_o), W'(ef));
    mc = ec; mf = ef;
  endtask

  task automatic run_div(logic s, logic [W-1:0] x, logic [W-1:0] y, logic inj);
    logic [W-1:0] eq;
    if (!s) eq = (y == '0) ? '0 : x / y;
    else if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) eq = 32'h8000_0000;
    else eq = (y == '0) ? '0 : W'($signed(x) / $signed(y));
    @(negedge clk);
    op = s ? OP_DIV : OP_DIVU; a = x; b = y; en = 1'b1; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    if (y == '0) begin
      check("R12", "illegal", W'(illegal_o), W'(1));
      check("R12", "res_valid", W'(res_valid_o), W'(0));
      check("R12", "busy", W'(busy_o), W'(0));
      check("R12", "carry", W'(carry_o), W'(mc));
      check("R12", "flag", W'(flag_o), W'(mf));
      return;
    end
    check("R11", "busy", W'(busy_o), W'(1));
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      if (inj && k == 1) begin
        op = OP_ADD; a = '0; b = '0; en = 1'b1; valid = 1'b1;
      end
      if (inj && k == 2) valid = 1'b0;
      if (k < W) check(inj ? "R13" : "R11", "early res_valid", W'(res_valid_o), W'(0));
    end
    check("R11", "res_valid", W'(res_valid_o), W'(1));
    check("R11", "busy", W'(busy_o), W'(0));
    check("R11", "quotient", res_o, eq);
    check("R13", "carry", W'(carry_o), W'(mc));
    check("R13", "flag", W'(flag_o), W'(mf));
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++; total++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R14", "res_valid", W'(res_valid_o), W'(0));
    check("R14", "busy", W'(busy_o), W'(0));
    check("R14", "illegal", W'(illegal_o), W'(0));
    check("R14", "carry", W'(carry_o), W'(0));
    check("R14", "flag", W'(flag_o), W'(0));
    rst_ni = 1'b1;
    @(negedge clk);
    check("R14", "res_valid idle", W'(res_valid_o), W'(0));

    // directed corners
    run_single(OP_ADD, 32'hFFFF_FFFF, 32'h1, 1'b1);      // R3 wrap sets carry, R4 zero flag
    run_single(OP_ADDC, 32'h5, 32'hFFFF_FFFF, 1'b1);     // R3 compare rule clears carry
    run_single(OP_ADD, 32'h7, 32'h9, 1'b0);              // R4 mode off keeps flag
    run_single(OP_CMOV, 32'hAAAA_0001, 32'h5555_0002, 1'b0);  // R9
    run_single(OP_AND, 32'hF0F0, 32'h0F0F, 1'b1);        // R4 AND zero
    run_single(OP_CMOV, 32'hAAAA_0001, 32'h5555_0002, 1'b0);  // R9 flag set
    run_single(OP_SUB, 32'h3, 32'h3, 1'b1);              // R5 zero sub, no flag change
    run_single(OP_ADDC, 32'h10, 32'h20, 1'b1);
    run_single(OP_FF1, 32'h0, 32'h0, 1'b0);              // R10 zero input
    run_single(OP_FF1, 32'h8000_0000, 32'h0, 1'b0);      // R10 top bit
    run_single(OP_SRA, 32'h8000_0010, 32'd36, 1'b0);     // R6 amount uses low bits
    run_single(OP_SLL, 32'h1, 32'hFFFF_FFE1, 1'b0);      // R6
    run_single(OP_MOVHI, 32'h0, 32'hDEAD_BEEF, 1'b0);    // R7
    run_single(OP_EXTBS, 32'h1234_5680, 32'h0, 1'b0);    // R8
    run_single(OP_EXTHZ, 32'hFFFF_8001, 32'h0, 1'b0);    // R8
    run_div(1'b1, 32'hFFFF_FFF9, 32'h2, 1'b0);           // R11 -7/2
    run_div(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);   // R11 overflow case
    run_div(1'b0, 32'hFFFF_FFFF, 32'h3, 1'b1);           // R13 request during busy
    run_div(1'b1, 32'h1234, 32'h0, 1'b0);                // R12
    run_div(1'b0, 32'h1234, 32'h0, 1'b0);                // R12

    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] x, y;
      x = $urandom;
      case ($urandom_range(0, 3))
        0: y = ~x;
        1: y = -x;
        2: y = W'($urandom_range(0, 40));
        default: y = $urandom;
      endcase
      run_single(5'($urandom_range(0, 15)), x, y, 1'($urandom_range(0, 1)));
    end
    for (int n = 0; n < 30; n++) begin
      logic [W-1:0] y;
      y = ($urandom_range(0, 5) == 0) ? '0 :
          ($urandom_range(0, 1) == 0) ? W'($urandom_range(1, 100)) : $urandom;
      run_div(1'($urandom_range(0, 1)), $urandom, y, 1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule